// File: doc/BRIEF.md
# Transmit-only serial memory streamer

This block reads a small byte memory one byte at a time and sends its contents out of an open-drain data line, clocked by a separate transmit clock. The transmit clock is asynchronous to the system clock. After reset the block first leaves the line released for a start-up preamble. It then sends every byte most significant bit first, and a released null bit follows each byte. When the last address has been sent, the address pointer returns to zero and streaming goes on with no gap.

A second clock line, which belongs to a bidirectional controller, is watched at the same time. Its first falling edge switches the block into bidirectional mode for good. From then on the block releases the data line, raises a mode flag and ignores the transmit clock. Only a reset brings the block back to transmit-only mode.

Both clock lines are brought into the system clock domain through synchronisers before their edges are detected. The memory is a synchronous read port. It returns data on the cycle after a read enable and holds that data until the next read.

Top module: `serial_dump_streamer`

## Requirements
- R1: After reset, `bidir_mode_o` is 0, `line_oe_o` is 0, `mem_rd_en_o` is 0 and `mem_rd_addr_o` is 0.
- R2: During the first nine rising edges of the transmit clock, `line_oe_o` stays 0. A single read of address 0 is issued on the ninth rising edge.
- R3: On the tenth rising edge, `line_oe_o` becomes 1 and `line_o` carries bit 7 of the byte at address 0.
- R4: Each later rising edge presents the next bit of the current byte, in order from bit 7 down to bit 0, with `line_oe_o` at 1.
- R5: The rising edge that follows bit 0 starts a null bit: `line_oe_o` goes to 0 and `line_o` reads 1. On that same edge, exactly one read of the next address is issued. Reads only happen while the line is released.
- R6: After the byte at the last address (127), the next read goes to address 0 and streaming carries on without extra edges.
- R7: A falling edge on `bclk_i` sets `bidir_mode_o` to 1 within three system clock cycles. While the mode is 1, `line_oe_o` is 0, and transmit clock edges cause no reads and no output change.
- R8: Once `bidir_mode_o` is 1, it stays 1 whatever `bclk_i` and `tclk_i` do. Only `rst_n` clears it.
- R9: While `bclk_i` is held high, transmit clock activity never sets `bidir_mode_o`.
- R10: Every read enable lasts exactly one system clock cycle. Each byte gets exactly one read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 1 | Transmit clock, asynchronous |
| bclk_i | input | 1 | Bidirectional controller clock line, asynchronous |
| mem_rd_data_i | input | 8 | Read data from the memory, valid from the cycle after a read |
| mem_rd_en_o | output | 1 | Single-cycle memory read enable |
| mem_rd_addr_o | output | 7 | Memory read address |
| line_o | output | 1 | Data-out value, 1 when released |
| line_oe_o | output | 1 | Data-out enable, 1 when the streamer drives the line |
| bidir_mode_o | output | 1 | 1 once the block has switched to bidirectional mode |

## Verification
A transmit clock edge reaches `line_o` and `line_oe_o` three system clock edges after the input changes: two synchroniser stages, then the output register. The matching read enable appears on that same edge, and its data is ready one cycle later. A falling `bclk_i` sets the mode flag after three edges as well. The bench holds each transmit clock phase for eight system cycles and waits at least five cycles after a `bclk_i` change. It drives inputs and samples outputs on falling clock edges, so every result has settled well before it is compared. Expected bits come from the bench's own memory pattern and its own count of transmit edges.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef enum logic [0:0] {ST_PRE, ST_RUN} seq_st_t;

  // next address with wrap to zero at the end of the memory
  function automatic int unsigned wrap_next(int unsigned a, int unsigned depth);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction

  // bit sent in a given slot: slot 0 is the MSB of a w-bit byte
  function automatic logic pick_bit(logic [63:0] b, int unsigned slot, int unsigned w);
    return b[w - 1 - slot];
  endfunction

endpackage

// File: rtl/sds_sync.sv
module sds_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2,
  parameter logic [N-1:0] FALL_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], async_i[g]};
    end
    if (FALL_SEL[g]) begin : g_fall
      assign edge_o[g] = ~chain[STAGES-1] & chain[STAGES];
    end else begin : g_rise
      assign edge_o[g] = chain[STAGES-1] & ~chain[STAGES];
    end
  end
endmodule

// File: rtl/sds_mode.sv
module sds_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic mode_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_o <= 1'b0;
    else if (set_i) mode_o <= 1'b1;
  end
endmodule

// File: rtl/sds_seq.sv
module sds_seq
  import sds_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int DW      = 8,
  parameter int PRE_LEN = 9,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          halt_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          line_o,
  output logic          oe_o,
  output logic          pre_active_o
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int SW  = $clog2(DW + 1);
  localparam logic [SW-1:0]  NULL_SLOT = SW'(DW);
  localparam logic [SW-1:0]  LAST_BIT  = SW'(DW - 1);
  localparam logic [PCW-1:0] PRE_LAST  = PCW'(PRE_LEN - 1);

  seq_st_t        st;
  logic [PCW-1:0] pre_cnt;
  logic [SW-1:0]  slot;
  logic [DW-1:0]  shreg;

  assign pre_active_o = (st == ST_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PRE;
      pre_cnt   <= '0;
      slot      <= NULL_SLOT;
      shreg     <= '0;
      rd_addr_o <= '0;
      rd_en_o   <= 1'b0;
      line_o    <= 1'b1;
      oe_o      <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      if (halt_i) begin
        oe_o   <= 1'b0;
        line_o <= 1'b1;
      end else if (step_i) begin
        case (st)
          ST_PRE: begin
            if (pre_cnt == PRE_LAST) begin
              st      <= ST_RUN;
              slot    <= NULL_SLOT;
              rd_en_o <= 1'b1;
            end else begin
              pre_cnt <= pre_cnt + 1'b1;
            end
          end
          default: begin
            if (slot == NULL_SLOT) begin
              shreg  <= rd_data_i;
              slot   <= '0;
              oe_o   <= 1'b1;
              line_o <= rd_data_i[DW-1];
            end else if (slot == LAST_BIT) begin
              slot      <= NULL_SLOT;
              oe_o      <= 1'b0;
              line_o    <= 1'b1;
              rd_addr_o <= AW'(wrap_next(int'(rd_addr_o), DEPTH));
              rd_en_o   <= 1'b1;
            end else begin
              slot   <= slot + 1'b1;
              line_o <= pick_bit(64'(shreg), int'(slot) + 1, DW);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_dump_streamer.sv
module serial_dump_streamer #(
  parameter int DEPTH       = 128,
  parameter int DW          = 8,
  parameter int PRE_LEN     = 9,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk_i,
  input  logic          bclk_i,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_rd_addr_o,
  output logic          line_o,
  output logic          line_oe_o,
  output logic          bidir_mode_o
);
  logic [1:0] edges;
  logic       tclk_rise;
  logic       bclk_fall;
  logic       halt;
  logic       pre_active;

  sds_sync #(.N(2), .STAGES(SYNC_STAGES), .FALL_SEL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({bclk_i, tclk_i}), .edge_o(edges)
  );

  assign tclk_rise = edges[0];
  assign bclk_fall = edges[1];

  sds_mode u_mode (
    .clk(clk), .rst_n(rst_n), .set_i(bclk_fall), .mode_o(bidir_mode_o)
  );

  assign halt = bidir_mode_o | bclk_fall;

  sds_seq #(.DEPTH(DEPTH), .DW(DW), .PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .step_i(tclk_rise), .halt_i(halt),
    .rd_data_i(mem_rd_data_i), .rd_en_o(mem_rd_en_o), .rd_addr_o(mem_rd_addr_o),
    .line_o(line_o), .oe_o(line_oe_o), .pre_active_o(pre_active)
  );
endmodule

// File: rtl/sds_chk.sv
module sds_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_active,
  input logic oe,
  input logic line,
  input logic rd_en,
  input logic mode
);
  a_r2_pre_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pre_active |-> !oe);
  a_r5_read_in_null: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !oe);
  a_r5_released_high: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> line);
  a_r7_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> (!oe && !rd_en));
  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> mode);
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
endmodule

bind serial_dump_streamer sds_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pre_active(pre_active), .oe(line_oe_o),
  .line(line_o), .rd_en(mem_rd_en_o), .mode(bidir_mode_o)
);

// File: tb/sim_serial_dump_streamer.sv
module sim_serial_dump_streamer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk = 1'b0;
  logic       bclk = 1'b1;
  logic [7:0] mem_q = '0;
  logic       rd_en, oe, line, mode;
  logic [6:0] rd_addr;
  int n_chk = 0, n_bad = 0, rd_cnt = 0, last_addr = -1;
  bit done = 0;

  always #2 clk = ~clk;

  serial_dump_streamer u0 (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk), .bclk_i(bclk),
    .mem_rd_data_i(mem_q), .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr),
    .line_o(line), .line_oe_o(oe), .bidir_mode_o(mode)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ (a >> 2));
  endfunction

  always @(posedge clk) if (rd_en) begin
    mem_q     <= pat(int'(rd_addr));
    rd_cnt    <= rd_cnt + 1;
    last_addr <= int'(rd_addr);
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tclk = 1'b1;
      repeat (8) @(negedge clk);
      tclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic exp_bit(string tag, int addr, int slot);
    chk({tag, " oe"}, int'(oe), slot < 8 ? 1 : 0);
    chk({tag, " line"}, int'(line), slot < 8 ? int'(pat(addr)[7 - slot]) : 1);
  endtask

  // pulses to apply, expected slot (8 = released), byte address, cumulative reads
  localparam int NV = 10;
  localparam int VEC [NV][4] = '{
    '{1, 8, 0, 0}, '{8, 8, 0, 1}, '{1, 0, 0, 1}, '{3, 3, 0, 1}, '{4, 7, 0, 1},
    '{1, 8, 0, 2}, '{1, 0, 1, 2}, '{7, 7, 1, 2}, '{1, 8, 1, 3}, '{1, 0, 2, 3}
  };

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 oe", int'(oe), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    chk("R1 addr", int'(rd_addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: vector walk over the start of the stream
    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v][0]);
      exp_bit($sformatf("R4 vec%0d", v), VEC[v][2], VEC[v][1]);
      chk($sformatf("R5 reads vec%0d", v), rd_cnt, VEC[v][3]);
      if (VEC[v][3] > 0)
        chk($sformatf("R2 read addr vec%0d", v), last_addr, VEC[v][3] - 1);
    end

    // R6: run to the last byte and across the wrap
    pulse(1125);
    exp_bit("R6 last byte", 127, 0);
    chk("R6 reads", rd_cnt, 128);
    chk("R6 last addr", last_addr, 127);
    chk("R9 mode low", int'(mode), 0);
    pulse(8);
    chk("R6 wrap addr", last_addr, 0);
    chk("R10 reads after wrap", rd_cnt, 129);
    pulse(1);
    exp_bit("R6 wrapped byte", 0, 0);

    // R7: falling bclk while the line is driven
    @(negedge clk) bclk = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 mode set", int'(mode), 1);
    chk("R7 oe released", int'(oe), 0);
    base = rd_cnt;
    pulse(12);
    chk("R7 no reads", rd_cnt, base);
    chk("R7 oe stays off", int'(oe), 0);

    // R8: later bclk edges do not leave the mode
    bclk = 1'b1;
    repeat (6) @(negedge clk);
    bclk = 1'b0;
    repeat (6) @(negedge clk);
    bclk = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 mode sticky", int'(mode), 1);

    // R8 R1: only reset clears the mode
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset clears mode", int'(mode), 0);
    chk("R1 oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse(9);
    chk("R2 restart oe", int'(oe), 0);
    pulse(1);
    exp_bit("R3 restart msb", 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule